// File: doc/BRIEF.md
# One-Bit Predictive Fault Checker for a Two-Bit Up/Down Counter

This block watches a two-bit up/down counter and reports, through a sticky error flag, any stuck-at fault in the counter's next-state logic or in its state register. The counter is left exactly as it is. The checker does not hold a full replica of the state. Each cycle it predicts only one bit of the coming state and stores that single bit. One cycle later it compares the stored bit against the matching bit of the counter's register. The bit to predict and compare comes from the parity of the present state. That choice is delayed by a register, so the comparison lines up with the stored prediction.

Each transition checks one bit, so a fault may take a few cycles to show. The fixed selection rule still gives every counter bit a check against a 0 and against a 1 for some transition. This covers every single stuck-at fault on the next-state outputs and on the register outputs. The top level holds the monitored counter, the predictor and the comparison stage. It also has a fault-injection port, so that the detection claims can be shown at the ports.

Top module: `spr_checker_top`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted, `cnt_state` reads 0 and `err` reads 0. The cycle that directly follows reset release makes no comparison.
- R2: With no fault injected, each rising clock edge moves `cnt_state` up by one modulo 4 when `dir_up` is 1, and down by one modulo 4 when `dir_up` is 0.
- R3: The checker predicts a single bit per transition. If the two bits of the present state are equal, it predicts bit 0 of the next state. If they differ, it predicts bit 1. After the edge, it compares only that bit of the state register. A corrupted bit that was not selected raises no error.
- R4: If no fault is injected, `err` never rises, for any sequence of `dir_up` values.
- R5: Once `err` is 1, it stays 1 until reset, even after the fault is removed. Reset returns it to 0.
- R6: A permanent fault is injected with `flt_en` = 1. The value it forces is `flt_val`. The site is `flt_site`: 0 = next-state bit 0, 1 = next-state bit 1, 2 = register output bit 0, 3 = register output bit 1. Each of the eight site/value combinations raises `err` within 64 cycles of random `dir_up` stimulus.
- R7: A mismatch seen during a cycle shows up on `err` after the following rising edge. Example: a next-state fault during the transition at edge N shows up on `err` after edge N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_up | input | 1 | Counter direction: 1 counts up, 0 counts down |
| flt_en | input | 1 | Enables the injected stuck-at fault |
| flt_site | input | 2 | Fault site: 0/1 next-state bit 0/1, 2/3 register bit 0/1 |
| flt_val | input | 1 | Value the faulted bit is stuck at |
| cnt_state | output | 2 | Read-only view of the counter state register (as faulted) |
| err | output | 1 | Sticky fault-detected flag |

## Verification
Some behaviours are checked by the assertions on every cycle. These are the counter's modulo-4 step when no fault is present, the one-cycle delay of the select, the persistence of the error flag, and the absence of any mismatch when no fault has been active for two cycles. Other behaviours only the bench scenarios can show. One is that a corrupted but unselected bit passes unflagged. Another is the exact edge on which a detected fault reaches `err`. A third is that each of the eight injected faults is caught within the latency bound under random direction sequences.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int unsigned ST_W      = 2;
    localparam int unsigned SITE_W    = $clog2(2 * ST_W);
    localparam int unsigned NS_BASE   = 0;
    localparam int unsigned REG_BASE  = ST_W;

    typedef logic [ST_W-1:0]   st_t;
    typedef logic [SITE_W-1:0] site_t;

    typedef struct packed {
        st_t st;
    } cnt_regs_t;

    typedef struct packed {
        logic valid;
        logic sel;
        logic pred;
        logic err;
    } chk_regs_t;
endpackage

// File: rtl/spr_counter.sv
module spr_counter
    import spr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dir_up,
    input  logic  flt_en,
    input  site_t flt_site,
    input  logic  flt_val,
    output st_t   state_o
);
    cnt_regs_t r_q, r_d;
    st_t view;
    st_t ns_raw;
    st_t ns_flt;

    // register outputs and next-state outputs, each bit optionally stuck
    for (genvar b = 0; b < ST_W; b++) begin : g_inject
        always_comb begin
            view[b] = r_q.st[b];
            if (flt_en && (flt_site == site_t'(REG_BASE + b)))
                view[b] = flt_val;
        end
        always_comb begin
            ns_flt[b] = ns_raw[b];
            if (flt_en && (flt_site == site_t'(NS_BASE + b)))
                ns_flt[b] = flt_val;
        end
    end

    always_comb begin
        r_d = r_q;
        if (dir_up)
            ns_raw = view + st_t'(1);
        else
            ns_raw = view - st_t'(1);
        r_d.st = ns_flt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign state_o = view;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(flt_en) && !flt_en) |->
        (state_o == ($past(dir_up) ? st_t'($past(state_o) + st_t'(1))
                                   : st_t'($past(state_o) - st_t'(1))))); // R2
endmodule

// File: rtl/spr_predictor.sv
module spr_predictor
    import spr_pkg::*;
(
    input  st_t  state_i,
    input  logic dir_up,
    output logic sel_o,
    output logic pred_o
);
    logic nb0;
    logic nb1;
    logic flip1;

    always_comb begin
        // low bit toggles on every step, whatever the direction
        nb0    = ~state_i[0];
        // high bit toggles when carrying (up, low=1) or borrowing (down, low=0)
        flip1  = ~(state_i[0] ^ dir_up);
        nb1    = state_i[1] ^ flip1;
        sel_o  = state_i[1] ^ state_i[0];
        pred_o = sel_o ? nb1 : nb0;
    end

    always_comb begin
        if (sel_o == 1'b0) begin
            AST_LOW_BIT_TOGGLES: assert (pred_o != state_i[0]); // R3
        end
    end
endmodule

// File: rtl/spr_compare.sv
module spr_compare
    import spr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  st_t  state_i,
    input  logic sel_i,
    input  logic pred_i,
    output logic mis_o,
    output logic err_o
);
    chk_regs_t r_q, r_d;
    logic      picked;

    always_comb begin
        r_d       = r_q;
        picked    = state_i[r_q.sel];
        mis_o     = r_q.valid && (picked != r_q.pred);
        r_d.valid = 1'b1;
        r_d.sel   = sel_i;
        r_d.pred  = pred_i;
        r_d.err   = r_q.err | mis_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign err_o = r_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R5
    AST_SEL_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (r_q.sel == $past(sel_i))); // R3
    AST_MISMATCH_REACHES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        mis_o |=> err_o); // R7
endmodule

// File: rtl/spr_checker_top.sv
module spr_checker_top
    import spr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir_up,
    input  logic       flt_en,
    input  logic [1:0] flt_site,
    input  logic       flt_val,
    output logic [1:0] cnt_state,
    output logic       err
);
    st_t  tap;
    logic sel_w;
    logic pred_w;
    logic mis_w;
    logic err_w;

    spr_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_up   (dir_up),
        .flt_en   (flt_en),
        .flt_site (site_t'(flt_site)),
        .flt_val  (flt_val),
        .state_o  (tap)
    );

    spr_predictor u_pred (
        .state_i (tap),
        .dir_up  (dir_up),
        .sel_o   (sel_w),
        .pred_o  (pred_w)
    );

    spr_compare u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (tap),
        .sel_i   (sel_w),
        .pred_i  (pred_w),
        .mis_o   (mis_w),
        .err_o   (err_w)
    );

    assign cnt_state = tap;
    assign err       = err_w;

    AST_NO_FALSE_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && !flt_en && !$past(flt_en) && !$past(flt_en, 2))
        |-> !mis_w); // R4
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !mis_w); // R1
endmodule

// File: tb/spr_checker_top_tb_top.sv
module spr_checker_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_up = 1'b0;
    logic       flt_en = 1'b0;
    logic [1:0] flt_site = 2'd0;
    logic       flt_val = 1'b0;
    logic [1:0] cnt_state;
    logic       err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    logic [1:0] model;

    spr_checker_top dut_i (
        .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .flt_en(flt_en),
        .flt_site(flt_site), .flt_val(flt_val), .cnt_state(cnt_state), .err(err)
    );

    always #10 clk = ~clk;

    function automatic logic [1:0] step_model(logic [1:0] s, logic up);
        return up ? s + 2'd1 : s - 2'd1;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; flt_en = 1'b0;
        cyc(); cyc();
        chk(cnt_state == 2'd0, "R1 state in reset", cnt_state, 0);
        chk(err == 1'b0, "R1 err in reset", err, 0);
        rst_n = 1'b1;
        model = 2'd0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4711));

        // R3 selected-bit fault: state 00, up, next-state bit0 stuck 0 for one edge
        do_reset();
        dir_up = 1; flt_en = 1; flt_site = 2'd0; flt_val = 0;
        cyc(); flt_en = 0;
        chk(cnt_state == 2'd0, "R3 fault took effect", cnt_state, 0);
        chk(err == 0, "R7 err not yet", err, 0);
        cyc();
        chk(err == 1, "R3 selected bit0 flagged", err, 1);
        // R5 sticky
        for (int i = 0; i < 20; i++) begin dir_up = 1'($urandom); cyc(); end
        chk(err == 1, "R5 err sticky", err, 1);

        // R3 unselected bit: state 00, up, next-state bit1 stuck 1 -> 11, bit0 still right
        do_reset();
        chk(err == 0, "R5 reset clears err", err, 0);
        dir_up = 1; flt_en = 1; flt_site = 2'd1; flt_val = 1;
        cyc(); flt_en = 0;
        chk(cnt_state == 2'd3, "R3 unselected fault took effect", cnt_state, 3);
        for (int i = 0; i < 6; i++) begin dir_up = 1'($urandom); cyc(); end
        chk(err == 0, "R3 unselected bit1 not flagged", err, 0);

        // R3 selected bit1: 00 up ->01, then up with next-state bit1 stuck 0
        do_reset();
        dir_up = 1; cyc();
        chk(cnt_state == 2'd1, "R2 up from 0", cnt_state, 1);
        flt_en = 1; flt_site = 2'd1; flt_val = 0;
        cyc(); flt_en = 0;
        chk(err == 0, "R7 err not yet bit1", err, 0);
        cyc();
        chk(err == 1, "R3 selected bit1 flagged", err, 1);

        // R3 unselected bit0 from state 01: up with next-state bit0 stuck 1 -> 11
        do_reset();
        dir_up = 1; cyc();
        flt_en = 1; flt_site = 2'd0; flt_val = 1;
        cyc(); flt_en = 0;
        chk(cnt_state == 2'd3, "R3 fault 01->11", cnt_state, 3);
        for (int i = 0; i < 6; i++) begin dir_up = 1'($urandom); cyc(); end
        chk(err == 0, "R3 unselected bit0 not flagged", err, 0);

        // R2 directed down wrap and R4 random fault-free run
        do_reset();
        dir_up = 0; cyc();
        chk(cnt_state == 2'd3, "R2 down wrap", cnt_state, 3);
        model = 2'd3;
        for (int i = 0; i < 2000; i++) begin
            logic d;
            d = 1'($urandom);
            dir_up = d;
            cyc();
            model = step_model(model, d);
            chk(cnt_state == model, "R2 random step", cnt_state, model);
            chk(err == 0, "R4 no false alarm", err, 0);
        end

        // R6 every site/value caught within 64 cycles
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 2; v++) begin
                int lat;
                do_reset();
                for (int i = 0; i < 4; i++) begin dir_up = 1'($urandom); cyc(); end
                chk(err == 0, "R4 clean before fault", err, 0);
                flt_site = 2'(s); flt_val = 1'(v); flt_en = 1;
                lat = 0;
                while (err == 0 && lat < 64) begin
                    dir_up = 1'($urandom); cyc(); lat++;
                end
                chk(err == 1, $sformatf("R6 site %0d val %0d detected", s, v), err, 1);
                flt_en = 0;
            end
        end

        do_reset();
        finish_run();
    end
endmodule